// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

A synchronous controller that lets on-chip logic read and write an external asynchronous static RAM of 32K bytes sitting on a single shared data bus. The user side is a one-shot request: the requester pulses `req_i` while the controller is idle, along with the address, a write flag and the write byte. `done_o` pulses for one clock when the access is complete. On reads, the byte is then present on `rdata_o`.

On the memory side the controller drives active-low chip-select, write-enable and output-enable strobes and the 15-bit address. The data bus is split into an output byte, a drive-enable and an input byte, so the pad ring can build the tri-state buffer. Every interval is a whole number of clock cycles, found by rounding a nanosecond-grade parameter up against the clock period parameter, with a floor of one cycle.

Reads hold select and output-enable low for the access window and capture the bus on its last cycle. Writes first hold output-enable high long enough for the memory's outputs to reach high impedance, then assert write-enable with the data driven, then raise write-enable while still driving for one recovery cycle. Output-enable stays high for the whole write, so the plain minimum pulse width applies.

Top module: `sram_if_ctrl`

## Requirements
- R1: While reset is held and in the cycle after its release, chip-select, write-enable and output-enable are all 1, the drive-enable is 0 and `done_o` is 0.
- R2: A read accepted at clock edge k holds chip-select and output-enable at 0 and write-enable at 1 from edge k to edge k+N_RD. N_RD is the largest of the rounded address-access, read-cycle and output-enable-to-valid times: 7 cycles with default parameters.
- R3: At edge k+N_RD a read captures the input bus onto `rdata_o` and raises `done_o`, and all three strobes return to 1 at that same edge. `rdata_o` keeps that byte until the next read completes.
- R4: A write accepted at edge k first spends N_HZ cycles with chip-select 0 and both write-enable and output-enable at 1, with the drive-enable off. N_HZ is the rounded output-disable-to-high-impedance time: 3 cycles with defaults.
- R5: Write-enable is then 0 for N_PUL cycles. N_PUL is the largest of the rounded pulse width, address-valid-to-end, data setup and the write-cycle remainder: 5 cycles with defaults. Output-enable stays 1 throughout the write.
- R6: The drive-enable turns on together with write-enable going low, stays on for exactly one cycle after write-enable returns to 1, and is never on while output-enable is 0. While it is on, `mem_dq_o` carries the requested write byte.
- R7: `mem_addr_o` changes only at an edge where chip-select was 1 before that edge. While chip-select is 0, the address equals the accepted request address.
- R8: A write completes at edge k+N_HZ+N_PUL+1 with `done_o` high for one clock; the written byte is later returned by a read of the same address.
- R9: `done_o` is high for exactly one clock per accepted request. A request is accepted only when the controller is idle, one cycle or more after the previous `done_o`. A request raised while an access is running is ignored and alters neither memory contents nor pin timing.
- R10: Requests to consecutive accesses may follow back to back: a request in the cycle after `done_o` starts the next access at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one-cycle pulse, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Last read byte |
| done_o | output | 1 | One-cycle completion strobe |
| mem_addr_o | output | 15 | Memory address |
| mem_cs_no | output | 1 | Memory chip-select, active low |
| mem_we_no | output | 1 | Memory write-enable, active low |
| mem_oe_no | output | 1 | Memory output-enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the memory bus |
| mem_dq_oe_o | output | 1 | Bus drive-enable |
| mem_dq_i | input | 8 | Byte received from the memory bus |

## Verification
The following patterns are run against a behavioural memory on the bench:
- Writes to the lowest and highest addresses and to alternating-bit addresses, then reads of them. These separate address or data bit swaps from timing faults.
- A read issued directly after a write, and a write issued directly after a read. These expose turnaround faults: a missing high-impedance wait, or drivers left on too long.
- A write request injected in the middle of a read, and a read injected in the middle of a write. These show whether busy-time requests are ignored, because the later read-back must return the older byte.
- A run of mixed accesses, compared pin by pin every cycle, which pins down every phase length.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } ctl_state_e;

  function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_m1_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (capture_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_if_ctrl.sv
module sram_if_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_RC_PS   = 25000,
  parameter int unsigned T_AA_PS   = 25000,
  parameter int unsigned T_OEV_PS  = 11000,
  parameter int unsigned T_OHZ_PS  = 10000,
  parameter int unsigned T_WC_PS   = 25000,
  parameter int unsigned T_WP_PS   = 20000,
  parameter int unsigned T_AW_PS   = 20000,
  parameter int unsigned T_DW_PS   = 10000,
  parameter int unsigned T_WR_PS   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned N_RD  = max2(max2(to_cycles(T_AA_PS, CLK_PS), to_cycles(T_RC_PS, CLK_PS)),
                                       to_cycles(T_OEV_PS, CLK_PS));
  localparam int unsigned N_HZ  = to_cycles(T_OHZ_PS, CLK_PS);
  localparam int unsigned N_REC = to_cycles(T_WR_PS, CLK_PS);
  localparam int unsigned N_WC  = to_cycles(T_WC_PS, CLK_PS);
  localparam int unsigned N_PAD = (N_WC > N_HZ + N_REC) ? (N_WC - N_HZ - N_REC) : 1;
  localparam int unsigned N_PUL = max2(max2(to_cycles(T_WP_PS, CLK_PS), to_cycles(T_AW_PS, CLK_PS)),
                                       max2(to_cycles(T_DW_PS, CLK_PS), N_PAD));
  localparam int unsigned N_MAX = max2(max2(N_RD, N_HZ), max2(N_PUL, N_REC));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  ctl_state_e       state_q, state_d;
  logic             load, last, accept, capture, done_d;
  logic [CNT_W-1:0] len_m1;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign capture = (state_q == ST_READ) && last;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    len_m1  = '0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        load    = 1'b1;
        state_d = wr_i ? ST_WSET : ST_READ;
        len_m1  = wr_i ? CNT_W'(N_HZ - 1) : CNT_W'(N_RD - 1);
      end
      ST_READ: if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_WSET: if (last) begin
        state_d = ST_WPUL;
        load    = 1'b1;
        len_m1  = CNT_W'(N_PUL - 1);
      end
      ST_WPUL: if (last) begin
        state_d = ST_WREC;
        load    = 1'b1;
        len_m1  = CNT_W'(N_REC - 1);
      end
      ST_WREC: if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes come straight from flops so no decode glitch reaches the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mem_cs_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      mem_cs_no   <= (state_d == ST_IDLE);
      mem_we_no   <= (state_d != ST_WPUL);
      mem_oe_no   <= (state_d != ST_READ);
      mem_dq_oe_o <= (state_d == ST_WPUL) || (state_d == ST_WREC);
      done_o      <= done_d;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .len_m1_i (len_m1),
    .last_o   (last)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .capture_i (capture),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/sram_if_ctrl_chk.sv
module sram_if_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o
);
  p_oe_high_in_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);

  p_we_needs_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_cs_no);

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_drive_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  p_drive_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |=> !mem_dq_oe_o);

  p_hz_before_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no) && !$past(mem_cs_no));

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && !$past(mem_cs_no)) |-> $stable(mem_addr_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_cs_no && mem_we_no && mem_oe_no);
endmodule

bind sram_if_ctrl sram_if_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_if_ctrl_test.sv
module sram_if_ctrl_test;
  localparam int CLK = 4;
  // cycle counts from the requirements: ceil(ns / 4)
  localparam int E_RD  = 7;  // max(25,25,11 ns)
  localparam int E_HZ  = 3;  // 10 ns
  localparam int E_PUL = 5;  // max(20,20,10 ns, 7-3-1)
  localparam int E_WL  = E_HZ + E_PUL + 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, dq_o;
  logic [7:0]  dq_in = 8'h00;
  logic [14:0] m_addr_o;
  logic done, cs_n, we_n, oe_n, dq_oe;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK/2) clk = ~clk;

  sram_if_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_o(done), .mem_addr_o(m_addr_o), .mem_cs_no(cs_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_in)
  );

  // behavioural memory on the pins
  logic [7:0] sram [int];
  always @(posedge clk) begin
    if (rst_n && !cs_n && !we_n) sram[int'(m_addr_o)] = dq_o;
  end
  always @(negedge clk) begin
    if (!cs_n && !oe_n) dq_in = sram.exists(int'(m_addr_o)) ? sram[int'(m_addr_o)] : 8'h5A;
    else                dq_in = 8'hzz;
  end

  // cycle reference model
  logic [7:0] ref_mem [int];
  bit m_busy, m_wr, m_done;
  int m_t;
  logic [14:0] m_addr;
  logic [7:0]  m_wd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_done = 0; m_t = 0; m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == (m_wr ? E_WL : E_RD)) begin
          m_busy = 0; m_done = 1;
          if (!m_wr) m_rd = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 8'h5A;
        end
      end else if (req) begin
        m_busy = 1; m_t = 0; m_wr = wr; m_addr = addr; m_wd = wdata;
        if (wr) ref_mem[int'(addr)] = wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // per-cycle pin comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_cs, e_we, e_oe, e_drv;
      e_cs  = !m_busy;
      e_oe  = !(m_busy && !m_wr);
      e_we  = !(m_busy && m_wr && m_t >= E_HZ && m_t < E_HZ + E_PUL);
      e_drv = m_busy && m_wr && m_t >= E_HZ;
      chk(cs_n == e_cs, "R2/R4 chip-select", cs_n, e_cs);
      chk(oe_n == e_oe, "R2/R5 output-enable", oe_n, e_oe);
      chk(we_n == e_we, "R5 write-enable", we_n, e_we);
      chk(dq_oe == e_drv, "R6 drive-enable", dq_oe, e_drv);
      chk(done == m_done, "R9 done", done, m_done);
      if (!cs_n) chk(m_addr_o == m_addr, "R7 address", m_addr_o, m_addr);
      if (dq_oe) chk(dq_o == m_wd, "R6 write byte", dq_o, m_wd);
      if (m_done && !m_wr) chk(rdata == m_rd, "R3 read byte", rdata, m_rd);
      if (!m_busy && !m_done) chk(rdata == m_rd, "R3 read byte held", rdata, m_rd);
    end
  end

  task automatic access(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
  endtask

  // issue one access and pulse a second request while it runs
  task automatic access_with_intruder(input bit w, input logic [14:0] a, input logic [7:0] d,
                                      input bit iw, input logic [14:0] ia, input logic [7:0] id);
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    req = 1; wr = iw; addr = ia; wdata = id;  // R9: must be ignored
    @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic expect_read(input logic [14:0] a, input logic [7:0] d, input string tag);
    access(0, a, d);
    chk(rdata == d, tag, rdata, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && we_n && oe_n, "R1 strobes in reset", {cs_n, we_n, oe_n}, 3'b111);
    chk(!dq_oe && !done, "R1 drive/done in reset", {dq_oe, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && !done, "R1 idle after reset",
        {cs_n, we_n, oe_n, dq_oe, done}, 5'b11100);

    access(1, 15'h0000, 8'h3C);                  // R8 lowest address
    access(1, 15'h7FFF, 8'hA5);                  // R8 highest address
    access(1, 15'h5555, 8'h0F);
    access(1, 15'h2AAA, 8'hF0);
    expect_read(15'h0000, 8'h3C, "R8 readback low");
    expect_read(15'h7FFF, 8'hA5, "R8 readback high");
    expect_read(15'h5555, 8'h0F, "R8 readback 5555");
    expect_read(15'h2AAA, 8'hF0, "R8 readback 2AAA");
    // R10: read directly after write, write directly after read
    access(1, 15'h0123, 8'h77);
    expect_read(15'h0123, 8'h77, "R10 read after write");
    access(1, 15'h0123, 8'h88);
    expect_read(15'h0123, 8'h88, "R10 write after read");
    // R9: intruding requests are ignored
    access_with_intruder(0, 15'h0000, 8'h00, 1, 15'h7FFF, 8'h11);
    expect_read(15'h7FFF, 8'hA5, "R9 write during read ignored");
    access_with_intruder(1, 15'h0456, 8'h99, 1, 15'h5555, 8'h22);
    expect_read(15'h5555, 8'h0F, "R9 write during write ignored");
    expect_read(15'h0456, 8'h99, "R9 running write kept");
    // mixed run
    for (int i = 0; i < 16; i++) access(1, 15'(i * 1931 + 7), 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++) expect_read(15'(i * 1931 + 7), 8'(i * 37 + 5), "R8 mixed readback");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule